// File: doc/BRIEF.md
# Distributed Arithmetic Table Initializer

This block fills a set of distributed arithmetic lookup-table RAMs once after reset, so that a filter datapath built around them can start work. The taps of the filter are split into groups of `TAPS` coefficients, and each group has its own table of `2^TAPS` words. The word stored at address `a` of a table is the signed sum of the group's coefficients whose position bit is set in `a`. The coefficients come from a shared buffer that presents all of them at once as one flat vector, together with a level or pulse saying they are all loaded.

A single adder engine builds every table in turn. The tables are filled one after another, never in parallel. Inside one table the engine walks the addresses in reflected Gray-code order. Each step then changes exactly one coefficient bit, so each new word is the previous word plus or minus one coefficient. One word leaves the block on every clock through a plain RAM write port made of a table select, an address, the data and a write enable. When the last word of the last table has been written, a ready flag rises and stays high until the next reset. The block is used only when the tables live in writable RAM. It is left out when the tables are fixed in logic.

Top module: `dalut_init`

## Requirements
- R1: While reset is held and in the first cycle after it, `ready` is 0 and `ramWe` is 0.
- R2: After reset the block makes no write for as long as `coefsLoaded` stays 0.
- R3: In the first clock after `coefsLoaded` is seen high, writes begin. `ramWe` is then high for exactly `NUM_LUTS * 2^TAPS` consecutive cycles, with one word written per cycle.
- R4: Tables are filled in ascending order of `ramSel`, starting at 0, and each table is finished before the next one starts. Within table s, write number i (counting from 0) goes to address `i ^ (i >> 1)`, so two successive writes to the same table differ in exactly one address bit.
- R5: The word written to address a of table s equals the sum of coefficients `c[s*TAPS + j]` over every bit j that is set in a. Coefficient k is the signed two's-complement field `coefsIn[k*COEF_W +: COEF_W]`. The word is `COEF_W + clog2(TAPS)` bits wide, in two's complement.
- R6: The word written to address 0 of every table is zero.
- R7: `ready` rises in the cycle right after the final write, is never high while `ramWe` is high, and stays high until the next reset.
- R8: Once `ready` is high, any further assertion of `coefsLoaded` is ignored: no write occurs and `ready` stays 1.
- R9: Full-scale coefficients (all at the most positive value, all at the most negative value, or alternating between the two) give exact table words with no wraparound.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| coefsLoaded | input | 1 | All coefficients present in the shared buffer |
| coefsIn | input | NUM_LUTS*TAPS*COEF_W | Flat coefficient vector, coefficient k at bits k*COEF_W upward |
| ramWe | output | 1 | Write enable of the table RAM port |
| ramSel | output | SEL_W | Which table RAM the write goes to |
| ramAddr | output | TAPS | Word address within the selected table |
| ramData | output | COEF_W+clog2(TAPS) | Table word to be written |
| ready | output | 1 | All tables initialized; filter may accept data |

## Verification
Several rules are checked by assertions on every cycle: the write enable and ready never overlap, ready never falls, the first write goes to table 0 at address 0, address 0 always carries a zero word, successive writes within one table change exactly one address bit, and the number of writes equals the table total when ready rises. The values of the words themselves, the exact Gray sequence, the exact cycle in which writing begins after the loaded flag, and the absence of any reaction to a second loaded flag can only be shown by the bench's scenarios. Those scenarios compare every captured write against a subset sum computed in software, using random and full-scale coefficient sets.

// File: rtl/dalut_pkg.sv
`timescale 1ns/1ps
package dalut_pkg;

  localparam int IDX_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FILL,
    ST_DONE
  } dalut_state_t;

  // Strobes from control to datapath for one clock
  typedef struct packed {
    logic             clr;     // accumulator back to zero
    logic             step;    // add or subtract one coefficient
    logic             add;     // 1: add, 0: subtract
    logic [IDX_W-1:0] bitIdx;  // tap position within the group
  } dalut_strobe_t;

endpackage

// File: rtl/dalut_ctrl.sv
`timescale 1ns/1ps
module dalut_ctrl
  import dalut_pkg::*;
#(
  parameter int TAPS     = 4,
  parameter int NUM_LUTS = 3,
  localparam int SEL_W   = (NUM_LUTS > 1) ? $clog2(NUM_LUTS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             coefsLoaded,
  output dalut_strobe_t    strobes,
  output logic [SEL_W-1:0] lutSel,
  output logic             ramWe,
  output logic [TAPS-1:0]  ramAddr,
  output logic             ready
);

  dalut_state_t     state;
  logic [TAPS-1:0]  cnt;
  logic [SEL_W-1:0] lut;
  logic [TAPS-1:0]  nextCnt;
  logic [TAPS-1:0]  curGray;
  logic [TAPS-1:0]  nextGray;
  logic [TAPS-1:0]  flip;
  logic             lastAddr;
  logic             lastLut;

  always_comb begin
    nextCnt  = cnt + TAPS'(1);
    curGray  = cnt ^ (cnt >> 1);
    nextGray = nextCnt ^ (nextCnt >> 1);
    flip     = curGray ^ nextGray;
    lastAddr = &cnt;
    lastLut  = (lut == SEL_W'(NUM_LUTS - 1));
  end

  // One strobe set per cycle; the Gray step flips exactly one tap bit
  always_comb begin
    strobes = '0;
    if (state == ST_FILL) begin
      if (lastAddr) begin
        strobes.clr = 1'b1;
      end else begin
        strobes.step = 1'b1;
        strobes.add  = |(flip & nextGray);
        for (int i = 0; i < TAPS; i++) begin
          if (flip[i]) strobes.bitIdx = IDX_W'(i);
        end
      end
    end else if (state == ST_IDLE) begin
      strobes.clr = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      lut   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (coefsLoaded) begin
            state <= ST_FILL;
            cnt   <= '0;
            lut   <= '0;
          end
        end
        ST_FILL: begin
          cnt <= nextCnt;
          if (lastAddr) begin
            if (lastLut) state <= ST_DONE;
            else         lut   <= lut + SEL_W'(1);
          end
        end
        default: ;
      endcase
    end
  end

  assign lutSel  = lut;
  assign ramWe   = (state == ST_FILL);
  assign ramAddr = curGray;
  assign ready   = (state == ST_DONE);

  // R7
  ready_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    ready |=> ready);

  // R7
  ready_we_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(ready && ramWe));

  // R2
  start_on_loaded_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ramWe) |-> $past(coefsLoaded));

  // R4
  first_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ramWe) |-> (ramAddr == '0 && lutSel == '0));

  // R4
  gray_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ramWe && $past(ramWe) && lutSel == $past(lutSel))
      |-> $countones(ramAddr ^ $past(ramAddr)) == 1);

  // R4
  sel_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> lutSel <= SEL_W'(NUM_LUTS - 1));

endmodule

// File: rtl/dalut_datapath.sv
`timescale 1ns/1ps
module dalut_datapath
  import dalut_pkg::*;
#(
  parameter int COEF_W   = 12,
  parameter int TAPS     = 4,
  parameter int NUM_LUTS = 3,
  localparam int GUARD_W  = (TAPS > 1) ? $clog2(TAPS) : 0,
  localparam int WORD_W   = COEF_W + GUARD_W,
  localparam int NUM_COEF = NUM_LUTS * TAPS,
  localparam int CI_W     = (NUM_COEF > 1) ? $clog2(NUM_COEF) : 1,
  localparam int SEL_W    = (NUM_LUTS > 1) ? $clog2(NUM_LUTS) : 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  dalut_strobe_t              strobes,
  input  logic [SEL_W-1:0]           lutSel,
  input  logic [NUM_COEF*COEF_W-1:0] coefsIn,
  output logic [WORD_W-1:0]          accOut
);

  logic signed [WORD_W-1:0] coefArr [NUM_COEF];
  logic signed [WORD_W-1:0] acc;
  logic signed [WORD_W-1:0] operand;
  logic        [CI_W-1:0]   coefIdx;

  // Unpack and sign-extend each coefficient to the table word width
  for (genvar g = 0; g < NUM_COEF; g++) begin : g_unpack
    assign coefArr[g] = WORD_W'($signed(coefsIn[g*COEF_W +: COEF_W]));
  end

  assign coefIdx = CI_W'(lutSel) * CI_W'(TAPS) + CI_W'(strobes.bitIdx);
  assign operand = coefArr[coefIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc <= '0;
    end else if (strobes.clr) begin
      acc <= '0;
    end else if (strobes.step) begin
      acc <= strobes.add ? acc + operand : acc - operand;
    end
  end

  assign accOut = acc;

endmodule

// File: rtl/dalut_init.sv
`timescale 1ns/1ps
module dalut_init
  import dalut_pkg::*;
#(
  parameter int COEF_W   = 12,
  parameter int TAPS     = 4,
  parameter int NUM_LUTS = 3,
  localparam int GUARD_W = (TAPS > 1) ? $clog2(TAPS) : 0,
  localparam int WORD_W  = COEF_W + GUARD_W,
  localparam int SEL_W   = (NUM_LUTS > 1) ? $clog2(NUM_LUTS) : 1
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                coefsLoaded,
  input  logic [NUM_LUTS*TAPS*COEF_W-1:0]     coefsIn,
  output logic                                ramWe,
  output logic [SEL_W-1:0]                    ramSel,
  output logic [TAPS-1:0]                     ramAddr,
  output logic [WORD_W-1:0]                   ramData,
  output logic                                ready
);

  localparam int TOTAL = NUM_LUTS * (1 << TAPS);
  localparam int CNT_W = $clog2(TOTAL + 1);

  dalut_strobe_t    strobes;
  logic [SEL_W-1:0] lutSel;

  dalut_ctrl #(
    .TAPS     (TAPS),
    .NUM_LUTS (NUM_LUTS)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .coefsLoaded (coefsLoaded),
    .strobes     (strobes),
    .lutSel      (lutSel),
    .ramWe       (ramWe),
    .ramAddr     (ramAddr),
    .ready       (ready)
  );

  dalut_datapath #(
    .COEF_W   (COEF_W),
    .TAPS     (TAPS),
    .NUM_LUTS (NUM_LUTS)
  ) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .lutSel  (lutSel),
    .coefsIn (coefsIn),
    .accOut  (ramData)
  );

  assign ramSel = lutSel;

  // Write tally for the completion check
  logic [CNT_W-1:0] writeCount;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      writeCount <= '0;
    else if (ramWe) writeCount <= writeCount + CNT_W'(1);
  end

  // R6
  zero_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ramWe && ramAddr == '0) |-> ramData == '0);

  // R3
  write_total_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ready) |-> writeCount == CNT_W'(TOTAL));

endmodule

// File: tb/dalut_init_bench.sv
`timescale 1ns/1ps
module dalut_init_bench;

  localparam int COEF_W   = 12;
  localparam int TAPS     = 4;
  localparam int NUM_LUTS = 3;
  localparam int WORD_W   = COEF_W + $clog2(TAPS);
  localparam int SEL_W    = (NUM_LUTS > 1) ? $clog2(NUM_LUTS) : 1;
  localparam int DEPTH    = 1 << TAPS;
  localparam int TOTAL    = NUM_LUTS * DEPTH;
  localparam int NUM_COEF = NUM_LUTS * TAPS;

  logic                         clk = 1'b0;
  logic                         rstN = 1'b0;
  logic                         coefsLoaded = 1'b0;
  logic [NUM_COEF*COEF_W-1:0]   coefs = '0;
  logic                         ramWe;
  logic [SEL_W-1:0]             ramSel;
  logic [TAPS-1:0]              ramAddr;
  logic [WORD_W-1:0]            ramData;
  logic                         ready;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  dalut_init #(
    .COEF_W   (COEF_W),
    .TAPS     (TAPS),
    .NUM_LUTS (NUM_LUTS)
  ) u_dalut_init (
    .clk         (clk),
    .rstN        (rstN),
    .coefsLoaded (coefsLoaded),
    .coefsIn     (coefs),
    .ramWe       (ramWe),
    .ramSel      (ramSel),
    .ramAddr     (ramAddr),
    .ramData     (ramData),
    .ready       (ready)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int expWord(int sel, int addr);
    int sum = 0;
    for (int j = 0; j < TAPS; j++) begin
      if ((addr >> j) & 1)
        sum += int'($signed(coefs[(sel*TAPS + j)*COEF_W +: COEF_W]));
    end
    return sum;
  endfunction

  task automatic doReset();
    rstN = 1'b0;
    coefsLoaded = 1'b0;
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    check(ready == 1'b0, "R1", "ready in reset", ready, 0);
    check(ramWe == 1'b0, "R1", "ramWe in reset", ramWe, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(ready == 1'b0 && ramWe == 1'b0, "R1", "ready|ramWe after reset",
          {ready, ramWe}, 0);
  endtask

  task automatic idleScenario();
    doReset();
    // R2: no writes while the loaded flag stays low
    for (int i = 0; i < 20; i++) begin
      check(ramWe == 1'b0 && ready == 1'b0, "R2", "idle without loaded flag",
            {ready, ramWe}, 0);
      @(negedge clk);
    end
  endtask

  task automatic fillScenario(input string name, input bit holdLevel, input bit fullScale);
    string tag5 = fullScale ? "R9" : "R5";
    doReset();
    @(negedge clk);
    coefsLoaded = 1'b1;
    @(negedge clk);
    if (!holdLevel) coefsLoaded = 1'b0;
    for (int i = 0; i < TOTAL; i++) begin
      int sel  = i / DEPTH;
      int idx  = i % DEPTH;
      int addr = idx ^ (idx >> 1);
      int e    = expWord(sel, addr);
      // R3: one write per consecutive cycle
      check(ramWe == 1'b1, "R3", {name, " write enable"}, ramWe, 1);
      // R4: table order and Gray address order
      check(ramSel == SEL_W'(sel), "R4", {name, " table select"}, ramSel, sel);
      check(ramAddr == TAPS'(addr), "R4", {name, " address"}, ramAddr, addr);
      // R5 / R9: subset sum
      check(ramData == WORD_W'(e), tag5, {name, " word"},
            int'($signed(ramData)), e);
      if (addr == 0) begin
        // R6: zero word at address 0
        check(ramData == '0, "R6", {name, " zero word"}, int'($signed(ramData)), 0);
      end
      check(ready == 1'b0, "R7", {name, " ready during fill"}, ready, 0);
      @(negedge clk);
    end
    // R7: ready right after last write
    check(ready == 1'b1, "R7", {name, " ready after fill"}, ready, 1);
    check(ramWe == 1'b0, "R3", {name, " writes stop"}, ramWe, 0);
    coefsLoaded = 1'b0;
    @(negedge clk);
    // R8: a new loaded flag is ignored once ready
    coefsLoaded = 1'b1;
    @(negedge clk);
    coefsLoaded = 1'b0;
    for (int i = 0; i < 2*DEPTH; i++) begin
      check(ramWe == 1'b0, "R8", {name, " no rewrite"}, ramWe, 0);
      check(ready == 1'b1, "R7", {name, " ready sticky"}, ready, 1);
      @(negedge clk);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    idleScenario();

    for (int k = 0; k < NUM_COEF; k++) coefs[k*COEF_W +: COEF_W] = COEF_W'($urandom);
    fillScenario("random pulse", 1'b0, 1'b0);

    for (int k = 0; k < NUM_COEF; k++) coefs[k*COEF_W +: COEF_W] = COEF_W'($urandom);
    fillScenario("random level", 1'b1, 1'b0);

    for (int k = 0; k < NUM_COEF; k++)
      coefs[k*COEF_W +: COEF_W] = {1'b0, {(COEF_W-1){1'b1}}};
    fillScenario("all max", 1'b0, 1'b1);

    for (int k = 0; k < NUM_COEF; k++)
      coefs[k*COEF_W +: COEF_W] = {1'b1, {(COEF_W-1){1'b0}}};
    fillScenario("all min", 1'b0, 1'b1);

    for (int k = 0; k < NUM_COEF; k++)
      coefs[k*COEF_W +: COEF_W] = (k % 2 == 0) ? {1'b0, {(COEF_W-1){1'b1}}}
                                               : {1'b1, {(COEF_W-1){1'b0}}};
    fillScenario("alternating", 1'b0, 1'b1);

    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    summary();
    $finish;
  end

endmodule